// File: doc/BRIEF.md
# Ethernet Transmit Exception Monitor

This block sits beside a 10 Mb/s half-duplex transmitter and watches one frame at a time for network faults. A clock enable marks each bit time. The block counts bit times from the first preamble bit. It checks that the looped-back receive path shows carrier for the whole frame. It separates collisions that the retry logic should handle from collisions that arrive after the slot time, which abandon the frame. After the frame ends, it waits for the transceiver's heartbeat pulse on the collision pair.

In twisted-pair mode the carrier loopback and the heartbeat window do not apply. In that mode the loss-of-carrier flag reports a jabber or link-fail condition, and the heartbeat error reports a failed link at the end of the frame. Per-frame flags clear when a new frame starts. The heartbeat error and the summary error stay set until software clears them.

Top module: `tx_exc_mon`

## Requirements
- R1: While and after reset, every output is low.
- R2: Bit count rule: the count is 0 in the cycle where `tx_active` is first seen high. It then rises by one on each later cycle with `bit_en` high while `tx_active` is high. In normal (AUI) mode, if `carrier` is never high during the frame, `lost_carrier` goes high one cycle after `tx_active` is first seen low, and `no_retry` goes high with it.
- R3: In AUI mode, if `carrier` goes low during the frame after having been high, `lost_carrier` is set at the end of the frame. This holds even if carrier returns before the end.
- R4: A collision seen while `tx_active` is high and the bit count is above 512 sets `late_col` and `no_retry` from the next cycle. It also gives a one-cycle `abort_tx` pulse in that next cycle.
- R5: A collision seen while `tx_active` is high and the bit count is 512 or less drives `norm_col` high in the same cycle. Such a collision does not set `late_col` and does not pulse `abort_tx`.
- R6: The bit count stops at 1023. A collision after a frame longer than 1023 bit times is still late.
- R7: In AUI mode, after the frame ends, the window opens. If no collision is seen in any cycle up to and including the cycle of the 40th following `bit_en` pulse, `sqe_err` is set on that 40th pulse. A collision on the 40th pulse or earlier prevents the error.
- R8: When `sqe_err` rises, `err_sum` is also set. `err_sum` is also set by a late collision. `exc_irq` pulses for one cycle when `lost_carrier` or `late_col` rises, and never for `sqe_err`.
- R9: A new frame start clears `lost_carrier` and `late_col` from the next cycle. A one-cycle `err_clear` clears `sqe_err` and `err_sum` from the next cycle. If a set and a clear fall in the same cycle, the set wins.
- R10: In 10BASE-T mode (`tbase_mode` = 1), `carrier` is ignored. At the frame end, `lost_carrier` is set if `jabber` or `link_fail` was high in any cycle of the frame. `sqe_err` is set at the frame end if `link_fail` is high then, and no heartbeat window runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One pulse per network bit time |
| tx_active | input | 1 | High while a frame is being sent |
| carrier | input | 1 | Carrier sense from the looped-back receive pair |
| collision | input | 1 | Collision presence |
| tbase_mode | input | 1 | 1 selects twisted-pair mode |
| jabber | input | 1 | Twisted-pair jabber indicator |
| link_fail | input | 1 | Twisted-pair link-fail indicator |
| err_clear | input | 1 | Write-one clear for `sqe_err` and `err_sum` |
| lost_carrier | output | 1 | Loss-of-carrier flag for the current frame |
| late_col | output | 1 | Late-collision flag for the current frame |
| abort_tx | output | 1 | One-cycle abandon-frame pulse |
| no_retry | output | 1 | Current frame must not be retried |
| norm_col | output | 1 | In-slot collision passed to the retry logic |
| exc_irq | output | 1 | Interrupt pulse for carrier or late-collision faults |
| sqe_err | output | 1 | Heartbeat error, sticky |
| err_sum | output | 1 | Summary error, sticky |

## Verification
Collisions are placed at bit counts 512, 513 and past saturation. This separates the normal-collision path from the abort path and shows that a long frame does not wrap back into the slot. Three carrier patterns are tried: present throughout, never present, and dropping mid-frame then returning. These tell a good loopback from both loss-of-carrier causes. Heartbeats are placed after the window closes and exactly on its last pulse, which pins the 40-bit edge. Twisted-pair frames with no fault, a jabber pulse, and a held link failure show that the carrier is ignored and that each indicator feeds the correct flag.

// File: rtl/tx_exc_pkg.sv
package tx_exc_pkg;

    localparam int DEF_CNT_W   = 10;
    localparam int DEF_SLOT    = 512;
    localparam int DEF_SQE_WIN = 40;

    typedef struct packed {
        logic lcar;
        logic lcol;
    } frame_flags_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } sqe_state_e;

    function automatic logic any_fault(input logic jab, input logic lf);
        return jab | lf;
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int CNT_W = tx_exc_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             tx_active,
    output logic             tx_start,
    output logic             tx_end,
    output logic [CNT_W-1:0] cnt_eff
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             tx_q;
    logic [CNT_W-1:0] cnt;

    assign tx_start = tx_active & ~tx_q;
    assign tx_end   = ~tx_active & tx_q;
    assign cnt_eff  = tx_start ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= 1'b0;
            cnt  <= '0;
        end else begin
            tx_q <= tx_active;
            if (tx_start)
                cnt <= '0;
            else if (tx_active && bit_en && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    // R6: the count holds at its top value while the frame continues
    p_cnt_saturates_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_active && !tx_start && cnt == CNT_MAX) |=> cnt == CNT_MAX);

endmodule

// File: rtl/tx_frame_chk.sv
module tx_frame_chk
    import tx_exc_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int SLOT  = DEF_SLOT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_active,
    input  logic             tx_start,
    input  logic             tx_end,
    input  logic [CNT_W-1:0] cnt_eff,
    input  logic             carrier,
    input  logic             collision,
    input  logic             tbase_mode,
    input  logic             jabber,
    input  logic             link_fail,
    output frame_flags_t     flags,
    output logic             abort_pulse,
    output logic             norm_col,
    output logic             lcol_event
);
    localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(SLOT);

    logic late_now;
    logic car_seen;
    logic car_dropped;
    logic tp_fault;

    assign late_now   = collision & tx_active & (cnt_eff > SLOT_C);
    assign norm_col   = collision & tx_active & ~late_now;
    assign lcol_event = late_now & ~flags.lcol;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags       <= '0;
            abort_pulse <= 1'b0;
            car_seen    <= 1'b0;
            car_dropped <= 1'b0;
            tp_fault    <= 1'b0;
        end else if (tx_start) begin
            flags       <= '0;
            abort_pulse <= 1'b0;
            car_seen    <= carrier;
            car_dropped <= 1'b0;
            tp_fault    <= any_fault(jabber, link_fail);
        end else begin
            if (tx_active) begin
                car_seen <= car_seen | carrier;
                if (car_seen && !carrier)
                    car_dropped <= 1'b1;
                if (any_fault(jabber, link_fail))
                    tp_fault <= 1'b1;
            end
            if (tx_end)
                flags.lcar <= tbase_mode ? tp_fault : (~car_seen | car_dropped);
            abort_pulse <= lcol_event;
            if (late_now)
                flags.lcol <= 1'b1;
        end
    end

    // R9: a frame start leaves both per-frame flags clear
    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> (!flags.lcar && !flags.lcol));

    // R4: late flag only rises after a collision during transmission
    p_late_needs_col_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.lcol) |-> ($past(collision) && $past(tx_active)));

    // R4: abort lasts exactly one cycle
    p_abort_single_r4: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);

    // R5: an in-slot collision never leads to an abort
    p_norm_no_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (norm_col && !flags.lcol) |=> !abort_pulse);

endmodule

// File: rtl/tx_sqe_chk.sv
module tx_sqe_chk
    import tx_exc_pkg::*;
#(
    parameter int SQE_WIN = DEF_SQE_WIN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic tx_start,
    input  logic tx_end,
    input  logic collision,
    input  logic tbase_mode,
    input  logic link_fail,
    input  logic lcol_event,
    input  logic err_clear,
    output logic sqe_err,
    output logic err_sum
);
    localparam int WIN_W = $clog2(SQE_WIN);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(SQE_WIN - 1);

    sqe_state_e       st;
    logic [WIN_W-1:0] win;
    logic             miss;
    logic             tp_set;
    logic             sqe_set;

    assign miss    = (st == SQ_WAIT) & ~collision & bit_en & (win == WIN_LAST) & ~tx_start;
    assign tp_set  = tx_end & tbase_mode & link_fail;
    assign sqe_set = miss | tp_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            win     <= '0;
            sqe_err <= 1'b0;
            err_sum <= 1'b0;
        end else begin
            if (tx_start) begin
                st <= SQ_IDLE;
            end else if (tx_end && !tbase_mode) begin
                st  <= SQ_WAIT;
                win <= '0;
            end else if (st == SQ_WAIT) begin
                if (collision || miss)
                    st <= SQ_IDLE;
                else if (bit_en)
                    win <= win + 1'b1;
            end

            if (sqe_set)
                sqe_err <= 1'b1;
            else if (err_clear)
                sqe_err <= 1'b0;

            if (sqe_set || lcol_event)
                err_sum <= 1'b1;
            else if (err_clear)
                err_sum <= 1'b0;
        end
    end

    // R8: a set heartbeat error is always reflected in the summary bit
    p_sum_covers_sqe_r8: assert property (@(posedge clk) disable iff (rst)
        sqe_err |-> err_sum);

    // R7: the window counter never passes its last slot
    p_win_bounded_r7: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_WAIT) |-> (win <= WIN_LAST));

    // R9: clear without a set empties both sticky bits
    p_clear_works_r9: assert property (@(posedge clk) disable iff (rst)
        (err_clear && !sqe_set && !lcol_event) |=> (!sqe_err && !err_sum));

endmodule

// File: rtl/tx_exc_mon.sv
module tx_exc_mon
    import tx_exc_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int SLOT    = DEF_SLOT,
    parameter int SQE_WIN = DEF_SQE_WIN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic tx_active,
    input  logic carrier,
    input  logic collision,
    input  logic tbase_mode,
    input  logic jabber,
    input  logic link_fail,
    input  logic err_clear,
    output logic lost_carrier,
    output logic late_col,
    output logic abort_tx,
    output logic no_retry,
    output logic norm_col,
    output logic exc_irq,
    output logic sqe_err,
    output logic err_sum
);
    logic             tx_start;
    logic             tx_end;
    logic [CNT_W-1:0] cnt_eff;
    logic             lcol_event;
    frame_flags_t     flags;
    frame_flags_t     flags_q;

    tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .tx_active(tx_active),
        .tx_start (tx_start),
        .tx_end   (tx_end),
        .cnt_eff  (cnt_eff)
    );

    tx_frame_chk #(.CNT_W(CNT_W), .SLOT(SLOT)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .tx_active  (tx_active),
        .tx_start   (tx_start),
        .tx_end     (tx_end),
        .cnt_eff    (cnt_eff),
        .carrier    (carrier),
        .collision  (collision),
        .tbase_mode (tbase_mode),
        .jabber     (jabber),
        .link_fail  (link_fail),
        .flags      (flags),
        .abort_pulse(abort_tx),
        .norm_col   (norm_col),
        .lcol_event (lcol_event)
    );

    tx_sqe_chk #(.SQE_WIN(SQE_WIN)) u_sqe (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .tx_start  (tx_start),
        .tx_end    (tx_end),
        .collision (collision),
        .tbase_mode(tbase_mode),
        .link_fail (link_fail),
        .lcol_event(lcol_event),
        .err_clear (err_clear),
        .sqe_err   (sqe_err),
        .err_sum   (err_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags;
    end

    assign lost_carrier = flags.lcar;
    assign late_col     = flags.lcol;
    assign no_retry     = flags.lcar | flags.lcol;
    assign exc_irq      = (flags.lcar & ~flags_q.lcar) | (flags.lcol & ~flags_q.lcol);

    // R8: heartbeat error alone raises no interrupt
    p_sqe_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(sqe_err) && !$rose(lost_carrier) && !$rose(late_col)) |-> !exc_irq);

    // R2: no_retry accompanies a carrier fault
    p_lcar_no_retry_r2: assert property (@(posedge clk) disable iff (rst)
        lost_carrier |-> no_retry);

endmodule

// File: tb/tx_exc_mon_bench.sv
module tx_exc_mon_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b1;
    logic tx_active = 1'b0, carrier = 1'b0, collision = 1'b0;
    logic tbase_mode = 1'b0, jabber = 1'b0, link_fail = 1'b0, err_clear = 1'b0;
    logic lost_carrier, late_col, abort_tx, no_retry, norm_col, exc_irq, sqe_err, err_sum;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tx_exc_mon u_tx_exc_mon (
        .clk(clk), .rst(rst), .bit_en(bit_en), .tx_active(tx_active),
        .carrier(carrier), .collision(collision), .tbase_mode(tbase_mode),
        .jabber(jabber), .link_fail(link_fail), .err_clear(err_clear),
        .lost_carrier(lost_carrier), .late_col(late_col), .abort_tx(abort_tx),
        .no_retry(no_retry), .norm_col(norm_col), .exc_irq(exc_irq),
        .sqe_err(sqe_err), .err_sum(err_sum)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic begin_frame(input logic car);
        tx_active = 1'b1;
        carrier   = car;
        tick(1);
    endtask

    task automatic end_frame();
        tx_active = 1'b0;
        carrier   = 1'b0;
        tick(1);
    endtask

    task automatic heartbeat();
        collision = 1'b1;
        tick(1);
        collision = 1'b0;
    endtask

    task automatic pulse_clear();
        err_clear = 1'b1;
        tick(1);
        err_clear = 1'b0;
    endtask

    task automatic t_reset();
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1", "lost_carrier", lost_carrier, 1'b0);
        chk("R1", "late_col", late_col, 1'b0);
        chk("R1", "abort_tx", abort_tx, 1'b0);
        chk("R1", "no_retry", no_retry, 1'b0);
        chk("R1", "norm_col", norm_col, 1'b0);
        chk("R1", "exc_irq", exc_irq, 1'b0);
        chk("R1", "sqe_err", sqe_err, 1'b0);
        chk("R1", "err_sum", err_sum, 1'b0);
    endtask

    task automatic t_good();
        begin_frame(1'b1);
        tick(99);
        end_frame();
        chk("R2", "good frame lost_carrier", lost_carrier, 1'b0);
        chk("R8", "good frame exc_irq", exc_irq, 1'b0);
        heartbeat();
        tick(50);
        chk("R7", "heartbeat seen sqe_err", sqe_err, 1'b0);
    endtask

    task automatic t_nocar();
        begin_frame(1'b0);
        tick(100);
        chk("R2", "no carrier before end", lost_carrier, 1'b0);
        end_frame();
        chk("R2", "no carrier lost_carrier", lost_carrier, 1'b1);
        chk("R2", "no carrier no_retry", no_retry, 1'b1);
        chk("R8", "carrier fault exc_irq", exc_irq, 1'b1);
        heartbeat();
        chk("R8", "exc_irq one cycle", exc_irq, 1'b0);
    endtask

    task automatic t_drop();
        begin_frame(1'b1);
        chk("R9", "start clears lost_carrier", lost_carrier, 1'b0);
        chk("R9", "start clears no_retry", no_retry, 1'b0);
        tick(20);
        carrier = 1'b0;
        tick(5);
        carrier = 1'b1;
        tick(50);
        end_frame();
        chk("R3", "carrier drop lost_carrier", lost_carrier, 1'b1);
        heartbeat();
    endtask

    task automatic t_col512();
        begin_frame(1'b1);
        tick(512);
        collision = 1'b1;
        #1;
        chk("R5", "norm_col at 512", norm_col, 1'b1);
        tick(1);
        collision = 1'b0;
        chk("R5", "late_col at 512", late_col, 1'b0);
        chk("R5", "abort_tx at 512", abort_tx, 1'b0);
        tick(20);
        end_frame();
        heartbeat();
    endtask

    task automatic t_col513();
        begin_frame(1'b1);
        tick(513);
        collision = 1'b1;
        #1;
        chk("R5", "norm_col at 513", norm_col, 1'b0);
        tick(1);
        collision = 1'b0;
        chk("R4", "late_col at 513", late_col, 1'b1);
        chk("R4", "abort_tx pulse", abort_tx, 1'b1);
        chk("R4", "no_retry late", no_retry, 1'b1);
        chk("R8", "late exc_irq", exc_irq, 1'b1);
        chk("R8", "late err_sum", err_sum, 1'b1);
        tick(1);
        chk("R4", "abort_tx ends", abort_tx, 1'b0);
        chk("R4", "late_col holds", late_col, 1'b1);
        end_frame();
        heartbeat();
        pulse_clear();
        chk("R9", "err_clear err_sum", err_sum, 1'b0);
        begin_frame(1'b1);
        chk("R9", "start clears late_col", late_col, 1'b0);
        tick(10);
        end_frame();
        heartbeat();
    endtask

    task automatic t_sat();
        begin_frame(1'b1);
        tick(1100);
        collision = 1'b1;
        tick(1);
        collision = 1'b0;
        chk("R6", "late after saturation", late_col, 1'b1);
        end_frame();
        heartbeat();
        pulse_clear();
    endtask

    task automatic t_sqe();
        begin_frame(1'b1);
        tick(100);
        end_frame();
        tick(39);
        chk("R7", "sqe before window end", sqe_err, 1'b0);
        tick(1);
        chk("R7", "sqe at 40th pulse", sqe_err, 1'b1);
        chk("R8", "sqe sets err_sum", err_sum, 1'b1);
        chk("R8", "sqe no exc_irq", exc_irq, 1'b0);
        pulse_clear();
        chk("R9", "clear sqe_err", sqe_err, 1'b0);
        chk("R9", "clear err_sum", err_sum, 1'b0);
        begin_frame(1'b1);
        tick(30);
        end_frame();
        tick(39);
        heartbeat();
        tick(10);
        chk("R7", "heartbeat on last pulse", sqe_err, 1'b0);
    endtask

    task automatic t_tbase();
        tbase_mode = 1'b1;
        begin_frame(1'b0);
        tick(100);
        end_frame();
        chk("R10", "tp no fault lost_carrier", lost_carrier, 1'b0);
        tick(50);
        chk("R10", "tp no window sqe", sqe_err, 1'b0);
        begin_frame(1'b0);
        tick(10);
        jabber = 1'b1;
        tick(1);
        jabber = 1'b0;
        tick(20);
        end_frame();
        chk("R10", "tp jabber lost_carrier", lost_carrier, 1'b1);
        chk("R10", "tp jabber sqe", sqe_err, 1'b0);
        begin_frame(1'b1);
        tick(10);
        link_fail = 1'b1;
        tick(20);
        end_frame();
        chk("R10", "tp link fail lost_carrier", lost_carrier, 1'b1);
        chk("R10", "tp link fail sqe", sqe_err, 1'b1);
        chk("R10", "tp link fail err_sum", err_sum, 1'b1);
        link_fail = 1'b0;
        tbase_mode = 1'b0;
        pulse_clear();
    endtask

    initial begin
        t_reset();
        t_good();
        t_nocar();
        t_drop();
        t_col512();
        t_col513();
        t_sat();
        t_sqe();
        t_tbase();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule